// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

This block collects eight edge-sensitive interrupt requests. It decides which one the processor should service and returns an 8-bit vector when the processor acknowledges. Software sees two byte-wide addresses. One is a command address, used to start configuration and to retire serviced interrupts. The other is a data address, which takes the configuration words and then holds the mask register.

Two copies can be chained so that sixteen requests share a single processor interrupt. The copy strapped as the primary one routes selected inputs to a secondary copy. When it acknowledges such an input, it does not produce a vector itself. Instead it drives the input's level number on a three-bit cascade bus. The secondary copy whose configured identity matches that number answers with its own vector in the same cycle.

Configuration starts with a command byte that has bit 4 set, for example 0x11. The next three data-address writes are then taken as configuration words:

- The first sets the vector base.
- The second is the cascade word. On the primary copy it lists the inputs that have secondaries; on a secondary copy its low three bits give the identity.
- The third selects the vector mode and is accepted as it is.

Top module: `legacy_intc`

## Requirements
- R1: After reset, irq_out is low, and both the mask (data-address read) and the in-service register (command-address read) read 0x00.
- R2: A command write with bit 4 set clears the mask, request and in-service registers. The next three data-address writes are taken as configuration words (vector base in bits 7:3, cascade word, mode word) and do not change the mask.
- R3: Once configured, a data-address write loads the mask, and a data-address read returns it unchanged. A 1 in bit n blocks input n.
- R4: A low-to-high transition of irq_req[n] sets request bit n. An input that simply stays high raises no further request after it has been acknowledged.
- R5: irq_out is high when configuration is complete and some unmasked pending request has a higher priority than every in-service level. Input 0 has the highest priority and input 7 the lowest.
- R6: An acknowledge while irq_out is high does three things in that cycle. It raises vec_valid with vec_out = {base[7:3], level}. It clears the winning request bit. It sets the matching in-service bit.
- R7: Command 0x20 clears the highest-priority bit set in the in-service register.
- R8: Command 0x60+L (L in 0..7) clears in-service bit L only, even when it is not the highest-priority bit.
- R9: A command-address read returns the in-service register.
- R10: On a primary copy (is_master high), acknowledging an input whose bit is set in the cascade word raises casc_drive with casc_out = level, and vec_valid stays low.
- R11: A secondary copy acts on an acknowledge only when casc_in equals the low three bits of its cascade word. Otherwise it gives no vector, and its in-service and request registers are left unchanged.
- R12: irq_out stays low before the first configuration and until the third configuration word has been written. Data writes made before the first configuration are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | Strap: 1 = primary copy, 0 = secondary copy |
| bus_sel | input | 1 | Address select: 0 = command, 1 = data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when bus_rd is low) |
| irq_req | input | 8 | Edge-sensitive request inputs |
| irq_out | output | 1 | Interrupt to the processor |
| irq_ack | input | 1 | Acknowledge pulse |
| vec_valid | output | 1 | Vector is being returned in this cycle |
| vec_out | output | 8 | Vector byte |
| casc_in | input | 3 | Cascade bus, as seen by a secondary copy |
| casc_drive | output | 1 | Primary copy is routing the acknowledge to a secondary copy |
| casc_out | output | 3 | Cascade level driven by the primary copy |

## Verification
The hardest state to reach is an acknowledge on the cascade bus that a secondary copy must decline. The request has to travel from the secondary copy's input, through its interrupt output, into the primary copy's input 2, and raise the primary copy's interrupt. Only then does the acknowledge arrive while the cascade bus carries some other identity. The bench does this with two chained instances. It lets a request ripple through both of them, then overrides the cascade lines for that one acknowledge. It then reads back the secondary copy's in-service register and checks that its interrupt output is still high.

// File: rtl/legacy_intc.sv
module legacy_intc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_master,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] irq_req,
  output logic       irq_out,
  input  logic       irq_ack,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  input  logic [2:0] casc_in,
  output logic       casc_drive,
  output logic [2:0] casc_out
);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_W2   = 3'd1;
  localparam logic [2:0] ST_W3   = 3'd2;
  localparam logic [2:0] ST_W4   = 3'd3;
  localparam logic [2:0] ST_RUN  = 3'd4;

  logic [2:0] st;
  logic [7:0] mask, irr, isr, req_q, cfg3;
  logic [4:0] base;

  function automatic logic [3:0] top_lvl(input logic [7:0] v);
    top_lvl = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) top_lvl = 4'(i);
  endfunction

  logic [3:0] p_lvl, s_lvl;
  logic [2:0] win;
  logic       selected, take, to_slave;
  logic       cmd_wr, data_wr, init_go, eoi_ns, eoi_sp;
  logic [7:0] eoi_clr, take_bit, rise;

  assign p_lvl    = top_lvl(irr & ~mask);
  assign s_lvl    = top_lvl(isr);
  assign win      = p_lvl[2:0];
  assign irq_out  = (st == ST_RUN) && (p_lvl < s_lvl);

  assign selected = is_master || (casc_in == cfg3[2:0]);
  assign take     = irq_ack && irq_out && selected;
  assign to_slave = is_master && cfg3[win];

  assign vec_valid  = take && !to_slave;
  assign vec_out    = vec_valid ? {base, win} : 8'h00;
  assign casc_drive = take && to_slave;
  assign casc_out   = casc_drive ? win : 3'd0;

  assign cmd_wr  = bus_wr && !bus_sel;
  assign data_wr = bus_wr && bus_sel;
  assign init_go = cmd_wr && bus_wdata[4];
  assign eoi_ns  = cmd_wr && bus_wdata[7:3] == 5'b00100;
  assign eoi_sp  = cmd_wr && bus_wdata[7:3] == 5'b01100;

  assign eoi_clr  = (eoi_ns && !s_lvl[3]) ? (8'd1 << s_lvl[2:0]) :
                    eoi_sp ? (8'd1 << bus_wdata[2:0]) : 8'h00;
  assign take_bit = take ? (8'd1 << win) : 8'h00;
  assign rise     = irq_req & ~req_q;

  assign bus_rdata = !bus_rd ? 8'h00 : (bus_sel ? mask : isr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      mask  <= 8'h00;
      irr   <= 8'h00;
      isr   <= 8'h00;
      req_q <= 8'h00;
      cfg3  <= 8'h00;
      base  <= 5'd0;
    end else begin
      req_q <= irq_req;
      if (init_go) begin
        mask <= 8'h00;
        irr  <= 8'h00;
        isr  <= 8'h00;
        st   <= ST_W2;
      end else begin
        irr <= (irr & ~take_bit) | rise;
        isr <= (isr & ~eoi_clr) | take_bit;
        if (data_wr) begin
          case (st)
            ST_W2:   begin base <= bus_wdata[7:3]; st <= ST_W3; end
            ST_W3:   begin cfg3 <= bus_wdata;      st <= ST_W4; end
            ST_W4:   st <= ST_RUN;
            ST_RUN:  mask <= bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> (st == ST_W2 && irr == 8'h00 && isr == 8'h00 && !irq_out));

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && st == ST_RUN) |=> mask == $past(bus_wdata));

  // R4
  one_new_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr & ~$past(isr)));

  // R5
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irr & ~mask) != 8'h00);

  // R6
  vector_marks_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !bus_wr) |=> isr[$past(vec_out[2:0])]);

  // R7
  eoi_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns && isr != 8'h00 && !take) |=> $countones(isr) == $countones($past(isr)) - 1);

endmodule

// File: tb/test_legacy_intc.sv
module test_legacy_intc;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic sel = 0, m_wr = 0, s_wr = 0, rd = 0, ack = 0;
  logic [7:0] wdata = 0, mreq = 0, sreq = 0;
  logic force_en = 0;
  logic [2:0] force_val = 0;

  logic [7:0] m_rdata, s_rdata, m_vec, s_vec;
  logic m_irq, s_irq, m_vv, s_vv, m_cd, s_cd;
  logic [2:0] m_co, s_co, s_cin;
  logic [7:0] m_req_in;

  assign m_req_in = {mreq[7:3], s_irq, mreq[1:0]};
  assign s_cin = force_en ? force_val : (m_cd ? m_co : 3'd0);

  legacy_intc i_legacy_intc (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .bus_sel(sel), .bus_wr(m_wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(m_rdata), .irq_req(m_req_in),
    .irq_out(m_irq), .irq_ack(ack), .vec_valid(m_vv), .vec_out(m_vec),
    .casc_in(3'd0), .casc_drive(m_cd), .casc_out(m_co));

  legacy_intc i_legacy_intc_slv (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .bus_sel(sel), .bus_wr(s_wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(s_rdata), .irq_req(sreq),
    .irq_out(s_irq), .irq_ack(ack), .vec_valid(s_vv), .vec_out(s_vec),
    .casc_in(s_cin), .casc_drive(s_cd), .casc_out(s_co));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", r, act, exp, $time);
    end
  endtask

  // Behavioural reference for the primary copy
  int md_phase;
  logic [7:0] md_mask, md_irr, md_isr, md_cas, md_prev;
  logic [4:0] md_base;

  function automatic int first1(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit exp_irq();
    return md_phase == 4 && first1(md_irr & ~md_mask) < first1(md_isr);
  endfunction

  always @(posedge clk or negedge rst_n) begin : ref_upd
    int lv, sv;
    logic [7:0] nirr, nisr;
    if (!rst_n) begin
      md_phase = 0; md_mask = 0; md_irr = 0; md_isr = 0;
      md_cas = 0; md_prev = 0; md_base = 0;
    end else begin
      lv = first1(md_irr & ~md_mask);
      nirr = md_irr; nisr = md_isr;
      if (m_wr && !sel && wdata == 8'h20) begin
        sv = first1(md_isr);
        if (sv < 8) nisr[sv] = 1'b0;
      end
      if (m_wr && !sel && wdata[7:3] == 5'b01100) nisr[wdata[2:0]] = 1'b0;
      if (ack && exp_irq()) begin
        nirr[lv] = 1'b0;
        nisr[lv] = 1'b1;
      end
      nirr = nirr | (m_req_in & ~md_prev);
      if (m_wr && !sel && wdata[4]) begin
        md_mask = 0; md_irr = 0; md_isr = 0; md_phase = 1;
      end else begin
        md_irr = nirr; md_isr = nisr;
        if (m_wr && sel) begin
          case (md_phase)
            1: begin md_base = wdata[7:3]; md_phase = 2; end
            2: begin md_cas = wdata; md_phase = 3; end
            3: md_phase = 4;
            4: md_mask = wdata;
            default: ;
          endcase
        end
      end
      md_prev = m_req_in;
    end
  end

  always @(negedge clk) begin : ref_cmp
    int lv;
    bit tk;
    logic [7:0] e_vec;
    if (rst_n && !done) begin
      lv = first1(md_irr & ~md_mask);
      tk = ack && exp_irq();
      e_vec = (tk && !md_cas[lv[2:0]]) ? {md_base, lv[2:0]} : 8'h00;
      check("R5 irq_out", {7'd0, m_irq}, {7'd0, exp_irq()});
      check("R6 vec_valid", {7'd0, m_vv}, {7'd0, tk && !md_cas[lv[2:0]]});
      check("R6 vec_out", m_vec, e_vec);
      check("R10 casc_drive", {7'd0, m_cd}, {7'd0, tk && md_cas[lv[2:0]]});
      check("R10 casc_out", {5'd0, m_co}, (tk && md_cas[lv[2:0]]) ? 8'(lv) : 8'h00);
      check("R3/R9 rdata", m_rdata, !rd ? 8'h00 : (sel ? md_mask : md_isr));
    end
  end

  task automatic nxt();
    @(posedge clk); #2;
  endtask

  task automatic wr(input bit to_m, input bit s, input logic [7:0] d);
    sel = s; wdata = d; m_wr = to_m; s_wr = !to_m;
    nxt();
    m_wr = 0; s_wr = 0;
  endtask

  task automatic rd_chk(input bit to_m, input bit s, input logic [7:0] e, input string r);
    sel = s; rd = 1;
    @(negedge clk);
    check(r, to_m ? m_rdata : s_rdata, e);
    nxt();
    rd = 0;
  endtask

  task automatic irq_chk(input bit m, input bit e, input string r);
    @(negedge clk);
    check(r, {7'd0, m ? m_irq : s_irq}, {7'd0, e});
    nxt();
  endtask

  task automatic ack_chk(input logic mvv, input logic [7:0] mvec, input logic mcd,
                         input logic [2:0] mco, input logic svv, input logic [7:0] svec,
                         input string r);
    ack = 1;
    @(negedge clk);
    check({r, " m_vv"}, {7'd0, m_vv}, {7'd0, mvv});
    check({r, " m_vec"}, m_vec, mvec);
    check({r, " m_cd"}, {7'd0, m_cd}, {7'd0, mcd});
    check({r, " m_co"}, {5'd0, m_co}, {5'd0, mco});
    check({r, " s_vv"}, {7'd0, s_vv}, {7'd0, svv});
    check({r, " s_vec"}, s_vec, svec);
    nxt();
    ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1;
    nxt();
    irq_chk(1, 0, "R1 irq after reset");
    rd_chk(1, 1, 8'h00, "R1 mask after reset");
    rd_chk(1, 0, 8'h00, "R1 isr after reset");

    wr(1, 1, 8'h55);
    rd_chk(1, 1, 8'h00, "R12 data write before config ignored");
    mreq[0] = 1; nxt(); nxt();
    irq_chk(1, 0, "R12 no irq before config");

    wr(1, 0, 8'h11);
    irq_chk(1, 0, "R12 no irq during config");
    wr(1, 1, 8'h20);
    wr(1, 1, 8'h04);
    irq_chk(1, 0, "R12 no irq before third word");
    wr(1, 1, 8'h01);
    rd_chk(1, 1, 8'h00, "R2 config words not in mask");
    irq_chk(1, 0, "R2 request cleared by config start");

    wr(0, 0, 8'h11); wr(0, 1, 8'h28); wr(0, 1, 8'h02); wr(0, 1, 8'h01);
    mreq[0] = 0;

    wr(1, 1, 8'hFB);
    rd_chk(1, 1, 8'hFB, "R3 mask readback");
    mreq[1] = 1; nxt(); nxt();
    irq_chk(1, 0, "R3 masked input blocked");
    wr(1, 1, 8'h00);
    irq_chk(1, 1, "R5 unmasked pending raises irq");
    ack_chk(1, 8'h21, 0, 3'd0, 0, 8'h00, "R6 ack level1");
    rd_chk(1, 0, 8'h02, "R9 isr after ack");
    irq_chk(1, 0, "R5 in-service blocks same level");

    mreq[5] = 1; nxt(); nxt();
    irq_chk(1, 0, "R5 lower priority blocked");
    mreq[0] = 1; nxt(); nxt();
    irq_chk(1, 1, "R5 higher priority nests");
    ack_chk(1, 8'h20, 0, 3'd0, 0, 8'h00, "R6 ack level0");
    rd_chk(1, 0, 8'h03, "R9 nested isr");
    wr(1, 0, 8'h61);
    rd_chk(1, 0, 8'h01, "R8 specific clears lower level");
    irq_chk(1, 0, "R5 level0 still blocks");
    wr(1, 0, 8'h20);
    rd_chk(1, 0, 8'h00, "R7 nonspecific clears highest");
    irq_chk(1, 1, "R5 level5 now allowed");
    ack_chk(1, 8'h25, 0, 3'd0, 0, 8'h00, "R6 ack level5");
    wr(1, 0, 8'h65);
    rd_chk(1, 0, 8'h00, "R8 specific clears level5");
    nxt();
    irq_chk(1, 0, "R4 held-high inputs do not retrigger");
    mreq = 0;

    sreq[3] = 1;
    repeat (3) nxt();
    irq_chk(1, 1, "R10 cascaded request reaches primary");
    ack_chk(0, 8'h00, 1, 3'd2, 1, 8'h2B, "R10 R11 cascaded ack");
    rd_chk(1, 0, 8'h04, "R9 primary isr cascade");
    rd_chk(0, 0, 8'h08, "R11 secondary isr");
    wr(0, 0, 8'h63);
    wr(1, 0, 8'h62);
    rd_chk(0, 0, 8'h00, "R8 secondary retired");
    rd_chk(1, 0, 8'h00, "R8 primary retired");
    sreq[3] = 0;

    sreq[4] = 1;
    repeat (3) nxt();
    force_en = 1; force_val = 3'd5;
    ack_chk(0, 8'h00, 1, 3'd2, 0, 8'h00, "R11 wrong identity");
    force_en = 0;
    rd_chk(0, 0, 8'h00, "R11 secondary isr untouched");
    irq_chk(0, 1, "R11 secondary request kept");

    wr(1, 0, 8'h11);
    rd_chk(1, 0, 8'h00, "R2 restart clears isr");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule